// File: doc/BRIEF.md
# Gated Slave Timer

This block is an up-counting timer meant to sit downstream of a master timer. A small register set picks one of several trigger lines and a slave-mode code. In gated mode the counter advances on prescaled ticks only while the run-enable bit is set and the chosen trigger is high. When the trigger drops, the counter stops where it is, and the prescaler phase stops with it.

Software can load any start value into the counter before or between gate windows. It can also issue a one-shot update strobe, which clears the counter and the prescaler phase together. When an upcount passes the reload value, the counter returns to zero and a sticky update flag is set.

Register map (3-bit address, data as wide as the counter): 0 control (bit 0 run enable); 1 mode (bits 2:0 slave mode, bits 6:4 trigger select); 2 counter preload; 3 prescaler ratio (one tick every ratio+1 clocks); 4 reload value; 5 status (bit 0 update flag); 6 event (bit 0 update strobe). Slave-mode code 000 means free-running under run enable alone, and 101 means gated.

Top module: `gated_slave_timer`

## Requirements
- R1: After reset the counter reads 0, the update flag is 0, run enable is off, the prescaler ratio is 0 and the reload value is all ones.
- R2: With slave mode 000 and run enable set, the counter advances by one every ratio+1 clocks, and it holds while run enable is clear. Counting takes effect from the first clock edge after the write to the control register.
- R3: With slave mode 101, the counter advances only while run enable is set and the selected trigger is high. The trigger passes through one register stage, so counting begins on the second edge after a rising trigger and still takes place on the first edge after a falling trigger.
- R4: While the gate is low, the counter and the prescaler phase both hold. The next window resumes from those exact values, so the total count equals (sum of window edges) / (ratio+1).
- R5: Mode bits 6:4 choose trigger input index n. An index of N_TRIG or above selects a constant low gate, and triggers that are not selected have no effect.
- R6: A write to address 2 loads the counter on that edge. Counting continues from the loaded value, and the load leaves the prescaler phase unchanged.
- R7: On a tick with the counter equal to the reload value, the counter goes to 0 and the update flag becomes 1.
- R8: Writing address 5 with bit 0 = 0 clears the update flag, and writing bit 0 = 1 leaves it unchanged. A wrap on the same edge as a clear leaves the flag at 1.
- R9: Writing address 6 with bit 0 = 1 sets the counter and the prescaler phase to 0 on that edge and does not set the update flag, even on a wrap edge. Counting resumes normally on the next edge.
- R10: Any slave-mode code other than 000 and 101 stops counting whatever the run enable and trigger values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W | Register write data |
| trig_in | input | N_TRIG | Trigger inputs from master timers |
| count_o | output | CNT_W | Current counter value |
| update_flag_o | output | 1 | Sticky update flag |

## Verification
Two pairs of actions can land on the same clock edge: a counter wrap together with a software clear of the update flag, and an update strobe together with a wrap tick. The bench counts edges from the run-enable write so that a status-clear write lands exactly on the wrap edge, and it then expects the flag to be 1 and the counter to be 0. A second sequence places the update strobe on the wrap edge and expects the counter at 0 with the flag still clear.

// File: rtl/gst_pkg.sv
package gst_pkg;

   localparam int ADDR_W = 3;
   localparam int FIELD_W = 3;

   localparam logic [FIELD_W-1:0] SM_FREE  = 3'b000;
   localparam logic [FIELD_W-1:0] SM_GATED = 3'b101;

   localparam int MODE_SMS_LSB = 0;
   localparam int MODE_TS_LSB  = 4;

   typedef enum logic [ADDR_W-1:0] {
      RA_CTRL = 3'd0,
      RA_MODE = 3'd1,
      RA_CNT  = 3'd2,
      RA_PSC  = 3'd3,
      RA_ARR  = 3'd4,
      RA_STAT = 3'd5,
      RA_EVT  = 3'd6
   } reg_addr_e;

   typedef struct packed {
      logic               run;
      logic [FIELD_W-1:0] sms;
      logic [FIELD_W-1:0] tsel;
   } ctl_t;

endpackage

// File: rtl/gst_regs.sv
module gst_regs
   import gst_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   output ctl_t              ctl,
   output logic [CNT_W-1:0]  ratio,
   output logic [CNT_W-1:0]  reload,
   output logic              ug_pulse,
   output logic              load_pulse,
   output logic              clr_pulse
);

   localparam int TS_HI  = MODE_TS_LSB + FIELD_W - 1;
   localparam int SMS_HI = MODE_SMS_LSB + FIELD_W - 1;

   if (CNT_W <= TS_HI) begin : g_bad_width
      $error("gst_regs: CNT_W too narrow for mode fields");
   end

   reg_addr_e addr;
   assign addr = reg_addr_e'(wr_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl    <= '0;
         ratio  <= '0;
         reload <= '1;
      end else if (wr_en) begin
         case (addr)
            RA_CTRL: ctl.run <= wr_data[0];
            RA_MODE: begin
               ctl.sms  <= wr_data[SMS_HI:MODE_SMS_LSB];
               ctl.tsel <= wr_data[TS_HI:MODE_TS_LSB];
            end
            RA_PSC:  ratio  <= wr_data;
            RA_ARR:  reload <= wr_data;
            default: ;
         endcase
      end
   end

   always_comb begin
      ug_pulse   = wr_en && (addr == RA_EVT) && wr_data[0];
      load_pulse = wr_en && (addr == RA_CNT);
      clr_pulse  = wr_en && (addr == RA_STAT) && !wr_data[0];
   end

endmodule

// File: rtl/gst_trig_gate.sv
module gst_trig_gate
   import gst_pkg::*;
#(
   parameter int N_TRIG = 4,
   parameter int STAGES = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_TRIG-1:0]  trig_in,
   input  logic [FIELD_W-1:0] tsel,
   output logic               gate
);

   localparam int MAX_TRIG = 1 << FIELD_W;

   if (N_TRIG < 1 || N_TRIG > MAX_TRIG) begin : g_bad_ntrig
      $error("gst_trig_gate: N_TRIG out of range");
   end
   if (STAGES < 1) begin : g_bad_stages
      $error("gst_trig_gate: STAGES must be at least 1");
   end

   logic [N_TRIG-1:0] hit;
   logic              picked;

   for (genvar i = 0; i < N_TRIG; i++) begin : g_sel
      assign hit[i] = trig_in[i] && (tsel == FIELD_W'(i));
   end

   assign picked = |hit;

   if (STAGES == 1) begin : g_one
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= picked;
      end
      assign gate = q;
   end else begin : g_chain
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '0;
         else        sh <= {sh[STAGES-2:0], picked};
      end
      assign gate = sh[STAGES-1];
   end

endmodule

// File: rtl/gst_prescaler.sv
module gst_prescaler #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             clear,
   input  logic [CNT_W-1:0] ratio,
   output logic             tick,
   output logic [CNT_W-1:0] phase
);

   logic at_end;
   assign at_end = (phase >= ratio);
   assign tick   = active && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       phase <= '0;
      else if (clear)   phase <= '0;
      else if (active)  phase <= at_end ? '0 : phase + 1'b1;
   end

   AST_PHASE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !clear) |=> $stable(phase)); // R4

   AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      clear |=> (phase == '0)); // R9

endmodule

// File: rtl/gst_counter.sv
module gst_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ug,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] reload,
   input  logic             flag_clr,
   output logic [CNT_W-1:0] cnt,
   output logic             flag
);

   logic wrap;
   logic set_evt;

   assign wrap    = (cnt == reload);
   assign set_evt = tick && wrap && !ug && !load;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (ug)    cnt <= '0;
      else if (load)  cnt <= load_val;
      else if (tick)  cnt <= wrap ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag <= 1'b0;
      else if (set_evt)  flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
   end

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ug && !load && cnt == reload) |=> (cnt == '0 && flag)); // R7

   AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !ug) |=> (cnt == $past(load_val))); // R6

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !flag_clr) |=> flag); // R8

endmodule

// File: rtl/gated_slave_timer.sv
module gated_slave_timer
   import gst_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int N_TRIG      = 4,
   parameter int TRIG_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [N_TRIG-1:0] trig_in,
   output logic [CNT_W-1:0]  count_o,
   output logic              update_flag_o
);

   if (CNT_W < 8) begin : g_bad_cnt
      $error("gated_slave_timer: CNT_W must be at least 8");
   end

   ctl_t             ctl;
   logic [CNT_W-1:0] ratio;
   logic [CNT_W-1:0] reload;
   logic             ug_pulse;
   logic             load_pulse;
   logic             clr_pulse;
   logic             gate;
   logic             mode_ok;
   logic             active;
   logic             tick;
   logic [CNT_W-1:0] phase;

   gst_regs #(.CNT_W(CNT_W)) i_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .ctl        (ctl),
      .ratio      (ratio),
      .reload     (reload),
      .ug_pulse   (ug_pulse),
      .load_pulse (load_pulse),
      .clr_pulse  (clr_pulse)
   );

   gst_trig_gate #(.N_TRIG(N_TRIG), .STAGES(TRIG_STAGES)) i_gate (
      .clk     (clk),
      .rst_n   (rst_n),
      .trig_in (trig_in),
      .tsel    (ctl.tsel),
      .gate    (gate)
   );

   always_comb begin
      case (ctl.sms)
         SM_FREE:  mode_ok = 1'b1;
         SM_GATED: mode_ok = gate;
         default:  mode_ok = 1'b0;
      endcase
      active = ctl.run && mode_ok;
   end

   gst_prescaler #(.CNT_W(CNT_W)) i_psc (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (active),
      .clear  (ug_pulse),
      .ratio  (ratio),
      .tick   (tick),
      .phase  (phase)
   );

   gst_counter #(.CNT_W(CNT_W)) i_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .ug       (ug_pulse),
      .load     (load_pulse),
      .load_val (wr_data),
      .reload   (reload),
      .flag_clr (clr_pulse),
      .cnt      (count_o),
      .flag     (update_flag_o)
   );

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !ug_pulse && !load_pulse) |=> $stable(count_o)); // R4

   AST_UG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      ug_pulse |=> (count_o == '0 && phase == '0)); // R9

   AST_UG_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (ug_pulse && !update_flag_o) |=> !update_flag_o); // R9

   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !ug_pulse && !load_pulse && count_o != reload)
      |=> (count_o == CNT_W'($past(count_o) + 1'b1))); // R2

   AST_OTHER_MODE_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl.sms != SM_FREE && ctl.sms != SM_GATED && !ug_pulse && !load_pulse)
      |=> $stable(count_o)); // R10

endmodule

// File: tb/test_gated_slave_timer.sv
module test_gated_slave_timer;

   localparam int CLK_PERIOD = 10;
   localparam int CW = 8;
   localparam int NT = 4;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_MODE = 3'd1;
   localparam logic [2:0] A_CNT  = 3'd2;
   localparam logic [2:0] A_PSC  = 3'd3;
   localparam logic [2:0] A_ARR  = 3'd4;
   localparam logic [2:0] A_STAT = 3'd5;
   localparam logic [2:0] A_EVT  = 3'd6;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [2:0]    wr_addr;
   logic [CW-1:0] wr_data;
   logic [NT-1:0] trig;
   logic [CW-1:0] count;
   logic          flag;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   gated_slave_timer #(.CNT_W(CW), .N_TRIG(NT), .TRIG_STAGES(1)) i_gated_slave_timer (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en         (wr_en),
      .wr_addr       (wr_addr),
      .wr_data       (wr_data),
      .trig_in       (trig),
      .count_o       (count),
      .update_flag_o (flag)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [CW-1:0] modev(input logic [2:0] sms, input logic [2:0] ts);
      return {1'b0, ts, 1'b0, sms};
   endfunction

   task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; trig = '0;
      run(3);
      rst_n = 1'b1;
      chk("R1 count", int'(count), 0);
      chk("R1 flag", int'(flag), 0);
      run(5);
      chk("R1 idle count", int'(count), 0);

      // R2 free-running sweep over prescaler ratio and run length
      wr(A_MODE, modev(3'b000, 3'd0));
      wr(A_ARR, 8'd255);
      for (int p = 0; p < 4; p++) begin
         for (int j = 0; j < 3; j++) begin
            int k;
            k = (j == 0) ? 1 : (j == 1) ? 5 : 12;
            wr(A_PSC, CW'(p));
            wr(A_EVT, 8'd1);
            wr(A_CTRL, 8'd1);
            run(k);
            chk("R2 running", int'(count), k / (p + 1));
            wr(A_CTRL, 8'd0);
            chk("R2 stop edge", int'(count), (k + 1) / (p + 1));
            run(4);
            chk("R2 hold off", int'(count), (k + 1) / (p + 1));
         end
      end

      // R3 / R4 gated windows with phase freeze
      for (int p = 0; p < 3; p++) begin
         for (int j = 0; j < 3; j++) begin
            int m1, m2;
            m1 = 2 * j + 1;
            m2 = 2 * j + 2 + j;
            wr(A_CTRL, 8'd0);
            wr(A_MODE, modev(3'b101, 3'd0));
            wr(A_PSC, CW'(p));
            trig = '0;
            wr(A_EVT, 8'd1);
            wr(A_CTRL, 8'd1);
            run(4);
            chk("R3 gate low", int'(count), 0);
            trig[0] = 1'b1; run(m1); trig[0] = 1'b0; run(3);
            chk("R4 first window", int'(count), m1 / (p + 1));
            trig[0] = 1'b1; run(m2); trig[0] = 1'b0; run(3);
            chk("R4 resume", int'(count), (m1 + m2) / (p + 1));
         end
      end
      wr(A_CTRL, 8'd0);
      trig[0] = 1'b1;
      run(5);
      chk("R3 gate high run off", int'(count), (5 + 8) / 3);
      trig = '0;

      // R5 trigger select sweep
      wr(A_PSC, 8'd0);
      wr(A_CTRL, 8'd1);
      for (int ts = 0; ts < NT; ts++) begin
         wr(A_MODE, modev(3'b101, 3'(ts)));
         wr(A_EVT, 8'd1);
         trig = ~(NT'(1) << ts);
         run(5);
         chk("R5 other inputs", int'(count), 0);
         trig = '0; run(2);
         trig = NT'(1) << ts; run(4);
         trig = '0; run(3);
         chk("R5 selected input", int'(count), 4);
      end
      begin
         int c0;
         c0 = int'(count);
         wr(A_MODE, modev(3'b101, 3'd5));
         trig = '1;
         run(6);
         chk("R5 out-of-range select", int'(count), c0);
         trig = '0;
      end

      // R6 preload
      wr(A_CTRL, 8'd0);
      wr(A_MODE, modev(3'b000, 3'd0));
      wr(A_ARR, 8'd255);
      wr(A_EVT, 8'd1);
      wr(A_CNT, 8'hE7);
      chk("R6 preload", int'(count), 231);
      wr(A_CTRL, 8'd1);
      run(5);
      chk("R6 count from preload", int'(count), 236);
      wr(A_CTRL, 8'd0);
      wr(A_MODE, modev(3'b101, 3'd1));
      wr(A_CTRL, 8'd1);
      wr(A_CNT, 8'h10);
      chk("R6 preload while gated", int'(count), 16);
      trig[1] = 1'b1; run(3); trig[1] = 1'b0; run(3);
      chk("R6 window from preload", int'(count), 19);

      // R7 wrap sweep
      for (int a = 3; a < 7; a++) begin
         wr(A_CTRL, 8'd0);
         wr(A_MODE, modev(3'b000, 3'd0));
         wr(A_PSC, 8'd0);
         wr(A_ARR, CW'(a));
         wr(A_STAT, 8'd0);
         wr(A_EVT, 8'd1);
         wr(A_CTRL, 8'd1);
         run(a);
         chk("R7 at reload", int'(count), a);
         chk("R7 flag before wrap", int'(flag), 0);
         run(1);
         chk("R7 wrapped", int'(count), 0);
         chk("R7 flag set", int'(flag), 1);
         run(2);
         chk("R7 after wrap", int'(count), 2);
      end
      wr(A_CTRL, 8'd0);
      wr(A_PSC, 8'd1);
      wr(A_ARR, 8'd3);
      wr(A_STAT, 8'd0);
      wr(A_EVT, 8'd1);
      wr(A_CTRL, 8'd1);
      run(7);
      chk("R7 prescaled before wrap", int'(flag), 0);
      run(1);
      chk("R7 prescaled wrap", int'(count), 0);
      chk("R7 prescaled flag", int'(flag), 1);

      // R8 flag clear and collision with wrap
      wr(A_CTRL, 8'd0);
      wr(A_STAT, 8'd1);
      chk("R8 write one keeps flag", int'(flag), 1);
      wr(A_STAT, 8'd0);
      chk("R8 clear", int'(flag), 0);
      wr(A_PSC, 8'd0);
      wr(A_ARR, 8'd9);
      wr(A_EVT, 8'd1);
      wr(A_CTRL, 8'd1);
      run(9);
      chk("R8 before collision", int'(count), 9);
      wr(A_STAT, 8'd0);
      chk("R8 set wins over clear", int'(flag), 1);
      chk("R8 wrap on collision", int'(count), 0);
      wr(A_STAT, 8'd0);
      chk("R8 later clear", int'(flag), 0);
      wr(A_CTRL, 8'd0);

      // R9 update strobe
      wr(A_PSC, 8'd2);
      wr(A_ARR, 8'd255);
      wr(A_EVT, 8'd1);
      wr(A_CTRL, 8'd1);
      run(4);
      chk("R9 pre-strobe", int'(count), 1);
      wr(A_EVT, 8'd1);
      chk("R9 strobe clears", int'(count), 0);
      run(2);
      chk("R9 phase cleared", int'(count), 0);
      run(1);
      chk("R9 first tick", int'(count), 1);
      wr(A_CTRL, 8'd0);
      wr(A_STAT, 8'd0);
      wr(A_PSC, 8'd0);
      wr(A_ARR, 8'd4);
      wr(A_EVT, 8'd1);
      wr(A_CTRL, 8'd1);
      run(4);
      chk("R9 at reload", int'(count), 4);
      wr(A_EVT, 8'd1);
      chk("R9 strobe on wrap edge", int'(count), 0);
      chk("R9 no flag", int'(flag), 0);
      run(3);
      chk("R9 resumes", int'(count), 3);

      // R10 other slave-mode codes
      for (int s = 0; s < 8; s++) begin
         if (s != 0 && s != 5) begin
            wr(A_CTRL, 8'd0);
            wr(A_EVT, 8'd1);
            wr(A_MODE, modev(3'(s), 3'd0));
            trig = '1;
            wr(A_CTRL, 8'd1);
            run(6);
            chk("R10 mode stops", int'(count), 0);
            trig = '0;
         end
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule